// File: doc/BRIEF.md
# Speculative Result Buffer with Operand Renaming

This block keeps every in-flight instruction in a circular buffer, in program order, from dispatch until it retires. Results arrive out of order, tagged with the index of the entry they belong to, and stay in that entry until the entry reaches the oldest position and retires. The architectural register file sits inside the block and has exactly one entry per logical register. It changes only when an entry retires, so the state visible to software always follows sequential order.

The entries also do the renaming. When issue logic asks for a source register, the block finds the youngest in-flight entry that will write that register. It returns that entry's result if the result is already present, or the entry index as a wait tag if it is not. If no in-flight entry writes the register, it returns the architectural value. A branch entry whose result reports a wrong prediction retires normally when it becomes the oldest, and all entries behind it are discarded in the same cycle.

Top module: `srq_top`

## Requirements
- R1: After reset the buffer is empty, every architectural register reads zero, no retirement or discard is signalled, and every lookup returns ready.
- R2: Each cycle, accepted dispatch slots take consecutive entry indexes starting at the tail. Slots are numbered in slot order, lowest first, and skipped slots take no index. `disp_tag` reports the index given to each accepted slot, 4 bits per slot at the default depth of 16.
- R3: `disp_stall` rises, and no slot is accepted, whenever the number of valid dispatch slots is larger than the number of free entries. Entries that retire in the same cycle do not count as free.
- R4: A writeback stores its data and marks its entry done only if that entry is occupied. A writeback to a free entry changes nothing. A wrong-prediction flag sent with a writeback counts only for entries dispatched as branches.
- R5: A lookup that matches an occupied entry uses the youngest such entry. If that entry is done, `lk_ready`=1 and `lk_data` is its result. If it is not done, `lk_ready`=0 and `lk_tag` is its index.
- R6: A lookup that matches no occupied entry returns `lk_ready`=1 with the architectural register value.
- R7: Up to CMT_N entries retire per cycle, only from the oldest position and only in order. Retirement stops at the first entry that is not done. `cmt_vld` bit k covers the k-th oldest entry.
- R8: Retiring entries report their destination and result on `cmt_reg`/`cmt_data` and write the architectural file, visible from the next cycle. When two entries retiring together write the same register, the younger value wins.
- R9: When a done branch entry flagged as mispredicted retires, `flush` is high in that cycle, no younger entry retires, and all younger entries are discarded. The buffer is empty in the next cycle.
- R10: Dispatch is refused (`disp_stall`=1) in a cycle when `flush` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | DISP_N | Dispatch slot valid |
| disp_dst | input | DISP_N*AREG_W | Destination logical register per slot |
| disp_br | input | DISP_N | Slot holds a branch |
| disp_stall | output | 1 | Dispatch refused this cycle |
| disp_tag | output | DISP_N*IDX_W | Entry index given to each slot |
| wb_vld | input | WB_N | Writeback port valid |
| wb_tag | input | WB_N*IDX_W | Entry index being completed |
| wb_data | input | WB_N*DATA_W | Result value |
| wb_mp | input | WB_N | Branch turned out mispredicted |
| lk_reg | input | LK_N*AREG_W | Source register to look up |
| lk_ready | output | LK_N | Operand value available |
| lk_tag | output | LK_N*IDX_W | Entry to wait on when not ready |
| lk_data | output | LK_N*DATA_W | Operand value when ready |
| cmt_vld | output | CMT_N | Retirement slot valid, oldest first |
| cmt_reg | output | CMT_N*AREG_W | Retiring destination register |
| cmt_data | output | CMT_N*DATA_W | Retiring result |
| flush | output | 1 | Younger entries discarded this cycle |

## Verification
A directed fill with every entry writing the same register separates youngest-match selection from oldest-match selection. It also drives the buffer to full, so that a single extra request must stall. Completing those entries from the youngest back to the oldest shows that retirement waits on the oldest entry. It then shows paired retirement and the rule that the younger of two writes to one register wins. A branch completed as mispredicted while a dispatch is requested checks the discard, the refused dispatch, and the return of lookups to the architectural value. Thousands of random cycles then mix partial dispatch bundles, out-of-order writebacks, writebacks to free entries, and wrong-prediction flags on non-branch entries. Each cycle is compared against a bench model of the queue.

// File: rtl/srq_pkg.sv
package srq_pkg;
   // Default geometry of the buffer
   localparam int SRQ_DEPTH_DEF  = 16;
   localparam int SRQ_DATA_W_DEF = 32;
   localparam int SRQ_NLOG_DEF   = 32;

   // Where a looked-up operand comes from
   typedef enum logic [1:0] {
      SRC_ARCH  = 2'd0,
      SRC_VALUE = 2'd1,
      SRC_WAIT  = 2'd2
   } src_kind_e;
endpackage

// File: rtl/srq_alloc.sv
module srq_alloc #(
   parameter int DEPTH  = 16,
   parameter int DISP_N = 2,
   parameter int IDX_W  = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DISP_N-1:0] disp_vld,
   input  logic             flush,
   input  logic [CNT_W-1:0] cmt_cnt,
   input  logic [IDX_W-1:0] head_nxt,
   output logic             stall,
   output logic [DISP_N-1:0] alloc_en,
   output logic [IDX_W-1:0] alloc_idx [DISP_N],
   output logic [CNT_W-1:0] count
);
   logic [IDX_W-1:0] tail;
   logic [CNT_W-1:0] req;
   logic [CNT_W-1:0] free;
   logic [CNT_W-1:0] acc;
   logic [CNT_W-1:0] pos;

   always_comb begin
      req = '0;
      for (int i = 0; i < DISP_N; i++) req = req + CNT_W'(disp_vld[i]);
      free  = CNT_W'(DEPTH) - count;
      stall = flush | (req > free);
      acc   = stall ? '0 : req;
      pos   = '0;
      for (int i = 0; i < DISP_N; i++) begin
         alloc_idx[i] = tail + pos[IDX_W-1:0];
         alloc_en[i]  = disp_vld[i] & ~stall;
         pos          = pos + CNT_W'(disp_vld[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail  <= '0;
         count <= '0;
      end else if (flush) begin
         tail  <= head_nxt;
         count <= '0;
      end else begin
         tail  <= tail + acc[IDX_W-1:0];
         count <= count + acc - cmt_cnt;
      end
   end
endmodule

// File: rtl/srq_commit.sv
module srq_commit #(
   parameter int DEPTH = 16,
   parameter int CMT_N = 2,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] ent_vld,
   input  logic [DEPTH-1:0] ent_done,
   input  logic [DEPTH-1:0] ent_bad,
   output logic [CMT_N-1:0] cmt_en,
   output logic [IDX_W-1:0] cmt_idx [CMT_N],
   output logic [CNT_W-1:0] cmt_cnt,
   output logic             flush,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] head_nxt
);
   logic go;

   always_comb begin
      go      = 1'b1;
      flush   = 1'b0;
      cmt_cnt = '0;
      for (int k = 0; k < CMT_N; k++) begin
         cmt_idx[k] = head + IDX_W'(k);
         cmt_en[k]  = go & ent_vld[cmt_idx[k]] & ent_done[cmt_idx[k]];
         if (cmt_en[k]) cmt_cnt = cmt_cnt + CNT_W'(1);
         if (cmt_en[k] & ent_bad[cmt_idx[k]]) flush = 1'b1;
         go = cmt_en[k] & ~ent_bad[cmt_idx[k]];
      end
      head_nxt = head + cmt_cnt[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) head <= '0;
      else        head <= head_nxt;
   end
endmodule

// File: rtl/srq_lookup.sv
module srq_lookup #(
   parameter int DEPTH  = 16,
   parameter int AREG_W = 5,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0]  head,
   input  logic [DEPTH-1:0]  ent_vld,
   input  logic [DEPTH-1:0]  ent_done,
   input  logic [AREG_W-1:0] ent_dst [DEPTH],
   input  logic [DATA_W-1:0] ent_val [DEPTH],
   input  logic [AREG_W-1:0] src_reg,
   input  logic [DATA_W-1:0] arch_val,
   output logic              ready,
   output logic [IDX_W-1:0]  tag,
   output logic [DATA_W-1:0] data
);
   import srq_pkg::*;
   logic             hit;
   logic [IDX_W-1:0] idx;
   src_kind_e        kind;

   // Scan oldest to youngest; the last match seen is the youngest writer
   always_comb begin
      hit = 1'b0;
      tag = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head + IDX_W'(k);
         if (ent_vld[idx] && ent_dst[idx] == src_reg) begin
            hit = 1'b1;
            tag = idx;
         end
      end
      if (!hit)               kind = SRC_ARCH;
      else if (ent_done[tag]) kind = SRC_VALUE;
      else                    kind = SRC_WAIT;
      case (kind)
         SRC_ARCH:  begin ready = 1'b1; data = arch_val;     end
         SRC_VALUE: begin ready = 1'b1; data = ent_val[tag]; end
         default:   begin ready = 1'b0; data = '0;           end
      endcase
   end
endmodule

// File: rtl/srq_archrf.sv
module srq_archrf #(
   parameter int NLOG   = 32,
   parameter int AREG_W = 5,
   parameter int DATA_W = 32,
   parameter int WR_N   = 2,
   parameter int RD_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WR_N-1:0]   we,
   input  logic [AREG_W-1:0] wa [WR_N],
   input  logic [DATA_W-1:0] wd [WR_N],
   input  logic [AREG_W-1:0] ra [RD_N],
   output logic [DATA_W-1:0] rd [RD_N]
);
   logic [DATA_W-1:0] regs [NLOG];

   // Later write ports override earlier ones: younger retirement wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NLOG; r++) regs[r] <= '0;
      end else begin
         for (int w = 0; w < WR_N; w++)
            if (we[w] && int'(wa[w]) < NLOG) regs[wa[w]] <= wd[w];
      end
   end

   always_comb begin
      for (int p = 0; p < RD_N; p++)
         rd[p] = (int'(ra[p]) < NLOG) ? regs[ra[p]] : '0;
   end
endmodule

// File: rtl/srq_top.sv
module srq_top #(
   parameter int DEPTH  = srq_pkg::SRQ_DEPTH_DEF,
   parameter int DATA_W = srq_pkg::SRQ_DATA_W_DEF,
   parameter int NLOG   = srq_pkg::SRQ_NLOG_DEF,
   parameter int AREG_W = $clog2(NLOG),
   parameter int DISP_N = 2,
   parameter int WB_N   = 2,
   parameter int LK_N   = 2,
   parameter int CMT_N  = 2,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DISP_N-1:0]        disp_vld,
   input  logic [DISP_N*AREG_W-1:0] disp_dst,
   input  logic [DISP_N-1:0]        disp_br,
   output logic                     disp_stall,
   output logic [DISP_N*IDX_W-1:0]  disp_tag,
   input  logic [WB_N-1:0]          wb_vld,
   input  logic [WB_N*IDX_W-1:0]    wb_tag,
   input  logic [WB_N*DATA_W-1:0]   wb_data,
   input  logic [WB_N-1:0]          wb_mp,
   input  logic [LK_N*AREG_W-1:0]   lk_reg,
   output logic [LK_N-1:0]          lk_ready,
   output logic [LK_N*IDX_W-1:0]    lk_tag,
   output logic [LK_N*DATA_W-1:0]   lk_data,
   output logic [CMT_N-1:0]         cmt_vld,
   output logic [CMT_N*AREG_W-1:0]  cmt_reg,
   output logic [CMT_N*DATA_W-1:0]  cmt_data,
   output logic                     flush
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
         $error("srq_top: DEPTH must be a power of two of at least 2");
      end
      if (DISP_N < 1 || DISP_N > DEPTH || CMT_N < 1 || CMT_N > DEPTH) begin : g_chk_width
         $error("srq_top: DISP_N and CMT_N must lie in 1..DEPTH");
      end
      if (NLOG < 2 || NLOG > (1 << AREG_W) || WB_N < 1 || LK_N < 1) begin : g_chk_regs
         $error("srq_top: register or port counts out of range");
      end
   endgenerate

   // Entry storage
   logic [DEPTH-1:0]  e_vld, e_done, e_br, e_mp;
   logic [AREG_W-1:0] e_dst [DEPTH];
   logic [DATA_W-1:0] e_val [DEPTH];

   // Unpacked views of the flat ports
   logic [AREG_W-1:0] d_dst [DISP_N];
   logic [IDX_W-1:0]  w_tag [WB_N];
   logic [DATA_W-1:0] w_dat [WB_N];
   logic [AREG_W-1:0] l_reg [LK_N];
   logic [DATA_W-1:0] l_arch [LK_N];
   logic [AREG_W-1:0] c_reg [CMT_N];
   logic [DATA_W-1:0] c_dat [CMT_N];

   genvar g;
   generate
      for (g = 0; g < DISP_N; g++) begin : g_disp
         assign d_dst[g] = disp_dst[g*AREG_W +: AREG_W];
      end
      for (g = 0; g < WB_N; g++) begin : g_wb
         assign w_tag[g] = wb_tag[g*IDX_W +: IDX_W];
         assign w_dat[g] = wb_data[g*DATA_W +: DATA_W];
      end
   endgenerate

   // Allocation and occupancy
   logic [DISP_N-1:0] alloc_en;
   logic [IDX_W-1:0]  alloc_idx [DISP_N];
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  cmt_cnt;
   logic [IDX_W-1:0]  head, head_nxt;
   logic [CMT_N-1:0]  cmt_en;
   logic [IDX_W-1:0]  cmt_idx [CMT_N];

   srq_alloc #(.DEPTH(DEPTH), .DISP_N(DISP_N), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_alloc (
      .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .flush(flush),
      .cmt_cnt(cmt_cnt), .head_nxt(head_nxt), .stall(disp_stall),
      .alloc_en(alloc_en), .alloc_idx(alloc_idx), .count(count)
   );

   generate
      for (g = 0; g < DISP_N; g++) begin : g_tag
         assign disp_tag[g*IDX_W +: IDX_W] = alloc_idx[g];
      end
   endgenerate

   // Retirement from the oldest position
   srq_commit #(.DEPTH(DEPTH), .CMT_N(CMT_N), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_commit (
      .clk(clk), .rst_n(rst_n), .ent_vld(e_vld), .ent_done(e_done),
      .ent_bad(e_br & e_mp), .cmt_en(cmt_en), .cmt_idx(cmt_idx),
      .cmt_cnt(cmt_cnt), .flush(flush), .head(head), .head_nxt(head_nxt)
   );

   assign cmt_vld = cmt_en;
   generate
      for (g = 0; g < CMT_N; g++) begin : g_cmt
         assign c_reg[g] = e_dst[cmt_idx[g]];
         assign c_dat[g] = e_val[cmt_idx[g]];
         assign cmt_reg[g*AREG_W +: AREG_W]  = c_reg[g];
         assign cmt_data[g*DATA_W +: DATA_W] = c_dat[g];
      end
   endgenerate

   // Architectural file: written only by retirement
   srq_archrf #(.NLOG(NLOG), .AREG_W(AREG_W), .DATA_W(DATA_W), .WR_N(CMT_N), .RD_N(LK_N)) i_arch (
      .clk(clk), .rst_n(rst_n), .we(cmt_en), .wa(c_reg), .wd(c_dat),
      .ra(l_reg), .rd(l_arch)
   );

   // One lookup unit per source port
   generate
      for (g = 0; g < LK_N; g++) begin : g_lk
         logic              rdy;
         logic [IDX_W-1:0]  tg;
         logic [DATA_W-1:0] dt;
         assign l_reg[g] = lk_reg[g*AREG_W +: AREG_W];
         srq_lookup #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_lk (
            .head(head), .ent_vld(e_vld), .ent_done(e_done), .ent_dst(e_dst),
            .ent_val(e_val), .src_reg(l_reg[g]), .arch_val(l_arch[g]),
            .ready(rdy), .tag(tg), .data(dt)
         );
         assign lk_ready[g]                 = rdy;
         assign lk_tag[g*IDX_W +: IDX_W]    = tg;
         assign lk_data[g*DATA_W +: DATA_W] = dt;
      end
   endgenerate

   // Entry updates: writeback, then retire, then discard, then allocate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vld  <= '0;
         e_done <= '0;
         e_br   <= '0;
         e_mp   <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_dst[i] <= '0;
            e_val[i] <= '0;
         end
      end else begin
         for (int w = 0; w < WB_N; w++) begin
            if (wb_vld[w] && e_vld[w_tag[w]]) begin
               e_done[w_tag[w]] <= 1'b1;
               e_val[w_tag[w]]  <= w_dat[w];
               e_mp[w_tag[w]]   <= wb_mp[w] & e_br[w_tag[w]];
            end
         end
         for (int c = 0; c < CMT_N; c++)
            if (cmt_en[c]) e_vld[cmt_idx[c]] <= 1'b0;
         if (flush) e_vld <= '0;
         for (int d = 0; d < DISP_N; d++) begin
            if (alloc_en[d]) begin
               e_vld[alloc_idx[d]]  <= 1'b1;
               e_done[alloc_idx[d]] <= 1'b0;
               e_mp[alloc_idx[d]]   <= 1'b0;
               e_br[alloc_idx[d]]   <= disp_br[d];
               e_dst[alloc_idx[d]]  <= d_dst[d];
            end
         end
      end
   end
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
   parameter int DEPTH  = 16,
   parameter int DISP_N = 2,
   parameter int CMT_N  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DISP_N-1:0] disp_vld,
   input logic              disp_stall,
   input logic [CMT_N-1:0]  cmt_vld,
   input logic              flush
);
   // Occupancy rebuilt from port activity only
   int occ;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      occ <= 0;
      else if (flush)  occ <= 0;
      else             occ <= occ + (disp_stall ? 0 : $countones(disp_vld)) - $countones(cmt_vld);
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ >= 0 && occ <= DEPTH);

   p_full_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == DEPTH && disp_vld != '0) |-> disp_stall);

   p_retire_contiguous_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmt_vld + CMT_N'(1)) & cmt_vld) == '0);

   p_retire_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cmt_vld) <= occ);

   p_flush_retires_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> cmt_vld[0]);

   p_flush_refuses_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> disp_stall);
endmodule

bind srq_top srq_checker #(.DEPTH(DEPTH), .DISP_N(DISP_N), .CMT_N(CMT_N)) i_srq_checker (
   .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_stall(disp_stall),
   .cmt_vld(cmt_vld), .flush(flush)
);

// File: tb/test_srq_top.sv
module test_srq_top;
   localparam int CLK_P = 10;
   localparam int DEP   = 16;
   localparam int NREG  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  disp_vld = '0;
   logic [9:0]  disp_dst = '0;
   logic [1:0]  disp_br = '0;
   logic        disp_stall;
   logic [7:0]  disp_tag;
   logic [1:0]  wb_vld = '0;
   logic [7:0]  wb_tag = '0;
   logic [63:0] wb_data = '0;
   logic [1:0]  wb_mp = '0;
   logic [9:0]  lk_reg = '0;
   logic [1:0]  lk_ready;
   logic [7:0]  lk_tag;
   logic [63:0] lk_data;
   logic [1:0]  cmt_vld;
   logic [9:0]  cmt_reg;
   logic [63:0] cmt_data;
   logic        flush;

   srq_top i_srq_top (.*);

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // Bench model of the queue
   bit          m_v [DEP], m_d [DEP], m_br [DEP], m_mp [DEP];
   logic [4:0]  m_dst [DEP];
   logic [31:0] m_val [DEP];
   logic [31:0] m_arch [NREG];
   int m_head, m_tail, m_cnt;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      disp_vld = '0; disp_br = '0; disp_dst = '0;
      wb_vld = '0; wb_mp = '0; wb_tag = '0; wb_data = '0;
   endtask

   function automatic bit exp_stall_f(input int nreq, input bit fl);
      return fl || (nreq > DEP - m_cnt);
   endfunction

   // One cycle: inputs already driven after a falling edge
   task automatic step();
      bit go, fl, est;
      logic [1:0] ecv;
      int ncm, nreq, pos, hidx, idx;
      bit hit;
      #1;
      go = 1; fl = 0; ncm = 0; ecv = '0;
      for (int k = 0; k < 2; k++) begin
         idx = (m_head + k) % DEP;
         ecv[k] = go && m_v[idx] && m_d[idx];
         if (ecv[k]) begin
            ncm++;
            if (m_br[idx] && m_mp[idx]) begin fl = 1; go = 0; end
         end else go = 0;
      end
      nreq = int'(disp_vld[0]) + int'(disp_vld[1]);
      est = exp_stall_f(nreq, fl);
      chk(disp_stall == est, fl ? "R10" : "R3", disp_stall, est);
      pos = 0;
      for (int p = 0; p < 2; p++) begin
         if (disp_vld[p] && !est) begin
            chk(disp_tag[p*4 +: 4] == 4'((m_tail + pos) % DEP), "R2", disp_tag[p*4 +: 4], (m_tail + pos) % DEP);
            pos++;
         end
      end
      for (int k = 0; k < 2; k++) begin
         idx = (m_head + k) % DEP;
         chk(cmt_vld[k] == ecv[k], "R7", cmt_vld[k], ecv[k]);
         if (ecv[k]) begin
            chk(cmt_reg[k*5 +: 5] == m_dst[idx], "R8", cmt_reg[k*5 +: 5], m_dst[idx]);
            chk(cmt_data[k*32 +: 32] == m_val[idx], "R8", cmt_data[k*32 +: 32], m_val[idx]);
         end
      end
      chk(flush == fl, "R9", flush, fl);
      for (int p = 0; p < 2; p++) begin
         hit = 0; hidx = 0;
         for (int k = 0; k < DEP; k++) begin
            idx = (m_head + k) % DEP;
            if (m_v[idx] && m_dst[idx] == lk_reg[p*5 +: 5]) begin hit = 1; hidx = idx; end
         end
         if (!hit) begin
            chk(lk_ready[p] == 1'b1, "R6", lk_ready[p], 1);
            chk(lk_data[p*32 +: 32] == m_arch[lk_reg[p*5 +: 5]], "R6", lk_data[p*32 +: 32], m_arch[lk_reg[p*5 +: 5]]);
         end else if (m_d[hidx]) begin
            chk(lk_ready[p] == 1'b1, "R5", lk_ready[p], 1);
            chk(lk_data[p*32 +: 32] == m_val[hidx], "R4", lk_data[p*32 +: 32], m_val[hidx]);
         end else begin
            chk(lk_ready[p] == 1'b0, "R5", lk_ready[p], 0);
            chk(lk_tag[p*4 +: 4] == 4'(hidx), "R5", lk_tag[p*4 +: 4], hidx);
         end
      end
      // Model update in the order the requirements give
      for (int w = 0; w < 2; w++) begin
         idx = int'(wb_tag[w*4 +: 4]);
         if (wb_vld[w] && m_v[idx]) begin
            m_d[idx] = 1; m_val[idx] = wb_data[w*32 +: 32]; m_mp[idx] = wb_mp[w] && m_br[idx];
         end
      end
      for (int k = 0; k < 2; k++) begin
         idx = (m_head + k) % DEP;
         if (ecv[k]) begin m_arch[m_dst[idx]] = m_val[idx]; m_v[idx] = 0; end
      end
      m_head = (m_head + ncm) % DEP;
      if (fl) begin
         for (int i = 0; i < DEP; i++) m_v[i] = 0;
         m_cnt = 0; m_tail = m_head;
      end else begin
         m_cnt -= ncm;
         if (!est) begin
            for (int p = 0; p < 2; p++) begin
               if (disp_vld[p]) begin
                  m_v[m_tail] = 1; m_d[m_tail] = 0; m_mp[m_tail] = 0;
                  m_br[m_tail] = disp_br[p]; m_dst[m_tail] = disp_dst[p*5 +: 5];
                  m_tail = (m_tail + 1) % DEP; m_cnt++;
               end
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R7 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int t0, a, b;
      void'($urandom(32'd4242));
      for (int i = 0; i < DEP; i++) begin
         m_v[i] = 0; m_d[i] = 0; m_br[i] = 0; m_mp[i] = 0; m_dst[i] = '0; m_val[i] = '0;
      end
      for (int r = 0; r < NREG; r++) m_arch[r] = '0;
      m_head = 0; m_tail = 0; m_cnt = 0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      lk_reg = {5'd9, 5'd3};
      #1;
      chk(cmt_vld == 2'b00, "R1", cmt_vld, 0);
      chk(flush == 1'b0, "R1", flush, 0);
      chk(disp_stall == 1'b0, "R1", disp_stall, 0);
      chk(lk_ready == 2'b11, "R1", lk_ready, 3);
      chk(lk_data == 64'd0, "R1", lk_data, 0);
      @(negedge clk);

      // Fill the buffer with writers of register 1
      lk_reg = {5'd2, 5'd1};
      for (int s = 0; s < 8; s++) begin
         idle(); disp_vld = 2'b11; disp_dst = {5'd1, 5'd1};
         step();
      end
      idle(); disp_vld = 2'b01; disp_dst = {5'd0, 5'd4};   // full: R3 stall expected
      step();
      // Complete youngest first; nothing may retire until entry 0 is done
      for (int t = DEP - 1; t > 0; t -= 2) begin
         idle(); wb_vld = 2'b11;
         wb_tag = {4'(t - 1), 4'(t)};
         wb_data = {32'(200 + t - 1), 32'(200 + t)};
         step();
      end
      idle();
      repeat (9) step();                                    // paired retirement, R8 same register

      // Mispredicted branch followed by a younger entry
      t0 = m_tail;
      idle(); disp_vld = 2'b11; disp_br = 2'b01; disp_dst = {5'd3, 5'd2};
      step();
      idle(); wb_vld = 2'b11; wb_mp = 2'b01;
      wb_tag = {4'((t0 + 1) % DEP), 4'(t0)};
      wb_data = {32'h33, 32'h22};
      lk_reg = {5'd3, 5'd2};
      step();
      idle(); disp_vld = 2'b11; disp_dst = {5'd6, 5'd5};   // R9 flush, R10 refused
      step();
      idle();
      step();                                               // register 3 back to architectural value

      // Random traffic
      for (int c = 0; c < 4000; c++) begin
         idle();
         disp_vld = 2'($urandom % 4);
         disp_br  = {($urandom % 4) == 0, ($urandom % 4) == 0};
         disp_dst = {5'($urandom % 8), 5'($urandom % 8)};
         a = $urandom % DEP;
         b = $urandom % DEP;
         wb_tag = {4'(b), 4'(a)};
         wb_data = {$urandom, $urandom};
         wb_vld[0] = (m_v[a] && !m_d[a]) || (!m_v[a] && ($urandom % 4) == 0);
         wb_vld[1] = (b != a) && ((m_v[b] && !m_d[b]) || (!m_v[b] && ($urandom % 4) == 0));
         wb_mp = {($urandom % 5) == 0, ($urandom % 5) == 0};
         lk_reg = {5'($urandom % 8), 5'($urandom % 8)};
         step();
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule